// File: doc/BRIEF.md
# Interrupt Capture Controller

This block gathers a parameterised set of raw interrupt lines and folds them into one request line for a processor. Each line is conditioned according to its own fixed setting: it is either edge-detected (rising or falling) or level-detected (active-high or active-low). Edge events are held in sticky pending bits until software clears them. Level lines produce a pending bit that simply tracks the line.

Pending bits are gated by per-source enables and by one global enable. The surviving bits are reduced to a single request. That request is presented either as a steady level or as a one-cycle pulse, with a selectable active polarity.

Software reaches the block through a plain register port. The port has a write strobe with address and data, and a combinational read path. Five word-aligned registers are provided: the global enable at 0x00, the source enables at 0x04, pending status at 0x08, write-one-to-clear acknowledge at 0x0C and live input status at 0x10.

Top module: `irq_capture_ctrl`

## Requirements
- R1: While reset is low, and right after it, all pending bits, all source enables and the global enable are zero, and the request output sits at its inactive level.
- R2: A source configured for rising edges (sensitivity bit 0, active-state bit 1) sets its pending bit at the first clock edge where its input is seen 1 after having been seen 0. A falling transition leaves it untouched.
- R3: A source configured for falling edges (sensitivity bit 0, active-state bit 0) sets its pending bit at the first clock edge where its input is seen 0 after having been seen 1.
- R4: An edge source whose input is already at its post-edge level, with no transition since reset or since the last acknowledge, raises no pending bit and no request when its enable is written to 1.
- R5: An edge pending bit stays set until a write to offset 0x0C has a 1 in that source's bit position. Writing 0 in that position has no effect. An edge arriving in the same cycle as the acknowledge keeps the bit set.
- R6: A level source (sensitivity bit 1) has a pending bit that equals "input equals active state" from one clock earlier. Writes to 0x0C do not clear it.
- R7: The request is active only while at least one source has both its pending bit and its enable bit (bit n of offset 0x04) set, and the global enable (bit 0 of offset 0x00) is 1.
- R8: In level output mode the request stays at its active value for as long as the condition of R7 holds, and the active value is selectable (1 high, 0 low).
- R9: In pulse output mode the request is active for exactly one cycle each time the gated pending set goes from empty to non-empty, and otherwise sits at its inactive value.
- R10: Offset 0x04 and 0x00 read back their written contents. Offset 0x10 returns the live inputs. Offset 0x08 returns pending bits and ignores writes. Any other offset reads zero.
- R11: An edge sets its pending bit even while that source or the global enable is disabled, so enabling it afterwards raises the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register and detection clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| src_i | input | NUM_SRC | Raw interrupt lines, one per source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Byte offset of the read |
| rd_data | output | 32 | Combinational read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that the raw inputs are already synchronous to the clock and that register writes use word-aligned offsets. An input change is taken to be seen at exactly one clock edge. The bench therefore changes inputs and write fields only just after a falling clock edge, holds every value for at least one full cycle, and addresses only defined offsets or deliberately unused aligned ones. Two instances with opposite polarities and output styles receive the same stimulus. This lets one input pattern exercise both rising and falling detection, and both level and pulse outputs.

// File: rtl/irq_cap_pkg.sv
package irq_cap_pkg;
  localparam int REG_AW = 5;
  localparam int REG_DW = 32;

  localparam logic [REG_AW-1:0] OFS_GLOBAL = 5'h00;
  localparam logic [REG_AW-1:0] OFS_ENABLE = 5'h04;
  localparam logic [REG_AW-1:0] OFS_PEND   = 5'h08;
  localparam logic [REG_AW-1:0] OFS_ACK    = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_RAW    = 5'h10;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_GLOBAL,
    SEL_ENABLE,
    SEL_ACK
  } wr_sel_e;
endpackage

// File: rtl/irq_src_cond.sv
module irq_src_cond #(
  parameter bit IS_LEVEL = 1'b0,
  parameter bit ACT_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  input  logic ack_i,
  output logic pend_o
);
  logic active;
  logic pend_d, pend_q;

  assign active = (src_i == ACT_HIGH);
  assign pend_o = pend_q;

  generate
    if (IS_LEVEL) begin : g_level
      logic unused_ack;
      assign unused_ack = ack_i;
      assign pend_d     = active;

      // R6: pending tracks the previous cycle's activity, ack has no say
      a_r6_level_track: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pend_q == ($past(src_i) == ACT_HIGH)));
    end else begin : g_edge
      logic prev_d, prev_q;
      logic seen_edge;

      // prev is refreshed every cycle, independent of any enable
      assign prev_d    = src_i;
      assign seen_edge = active && (prev_q != ACT_HIGH);
      assign pend_d    = seen_edge | (pend_q & ~ack_i);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= ACT_HIGH;
        else        prev_q <= prev_d;
      end

      // R4: with no input transition a clear bit stays clear
      a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_q && (src_i == prev_q)) |=> !pend_q);
      // R5: a set bit survives any cycle without acknowledge
      a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !ack_i) |=> pend_q);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file
  import irq_cap_pkg::*;
#(
  parameter int NUM_SRC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [REG_DW-1:0] wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [REG_DW-1:0] rd_data,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [NUM_SRC-1:0] raw_i,
  output logic              gen_en_o,
  output logic [NUM_SRC-1:0] src_en_o,
  output logic [NUM_SRC-1:0] ack_o
);
  wr_sel_e            wr_sel;
  logic               gen_d, gen_q;
  logic [NUM_SRC-1:0] en_d, en_q;
  logic               unused_wdata;

  assign unused_wdata = &{1'b0, wr_data};

  always_comb begin
    wr_sel = SEL_NONE;
    if (wr_en) begin
      unique case (wr_addr)
        OFS_GLOBAL: wr_sel = SEL_GLOBAL;
        OFS_ENABLE: wr_sel = SEL_ENABLE;
        OFS_ACK:    wr_sel = SEL_ACK;
        default:    wr_sel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    gen_d = gen_q;
    en_d  = en_q;
    if (wr_sel == SEL_GLOBAL) gen_d = wr_data[0];
    if (wr_sel == SEL_ENABLE) en_d  = wr_data[NUM_SRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q <= 1'b0;
      en_q  <= '0;
    end else begin
      gen_q <= gen_d;
      en_q  <= en_d;
    end
  end

  assign ack_o    = (wr_sel == SEL_ACK) ? wr_data[NUM_SRC-1:0] : '0;
  assign gen_en_o = gen_q;
  assign src_en_o = en_q;

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      OFS_GLOBAL: rd_data[0]           = gen_q;
      OFS_ENABLE: rd_data[NUM_SRC-1:0] = en_q;
      OFS_PEND:   rd_data[NUM_SRC-1:0] = pend_i;
      OFS_RAW:    rd_data[NUM_SRC-1:0] = raw_i;
      default:    rd_data              = '0;
    endcase
  end

  // R10: enable register changes only through a write to its offset
  a_r10_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == OFS_ENABLE) |=> $stable(src_en_o));
endmodule

// File: rtl/irq_out_gen.sv
module irq_out_gen #(
  parameter bit OUT_LEVEL = 1'b1,
  parameter bit OUT_HIGH  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic irq_o
);
  logic fire;

  generate
    if (OUT_LEVEL) begin : g_level
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign fire       = req_i;
    end else begin : g_pulse
      logic req_d, req_q;
      assign req_d = req_i;
      assign fire  = req_i & ~req_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req_d;
      end

      // R9: the pulse never lasts beyond one cycle
      a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o == OUT_HIGH) |=> (irq_o != OUT_HIGH));
    end
  endgenerate

  assign irq_o = OUT_HIGH ? fire : ~fire;
endmodule

// File: rtl/irq_capture_ctrl.sv
module irq_capture_ctrl
  import irq_cap_pkg::*;
#(
  parameter int          NUM_SRC   = 2,
  parameter logic [31:0] SRC_LEVEL = 32'hFFFF_FFFE,
  parameter logic [31:0] SRC_HIGH  = 32'hFFFF_FFFF,
  parameter bit          OUT_LEVEL = 1'b1,
  parameter bit          OUT_HIGH  = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en,
  input  logic [4:0]         wr_addr,
  input  logic [31:0]        wr_data,
  input  logic [4:0]         rd_addr,
  output logic [31:0]        rd_data,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] pend, src_en, ack, gated;
  logic               gen_en, any_req;

  irq_reg_file #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .pend_i   (pend),
    .raw_i    (src_i),
    .gen_en_o (gen_en),
    .src_en_o (src_en),
    .ack_o    (ack)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    irq_src_cond #(
      .IS_LEVEL (SRC_LEVEL[g]),
      .ACT_HIGH (SRC_HIGH[g])
    ) u_cond (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_i  (src_i[g]),
      .ack_i  (ack[g]),
      .pend_o (pend[g])
    );
  end

  assign gated   = pend & src_en & {NUM_SRC{gen_en}};
  assign any_req = |gated;

  irq_out_gen #(.OUT_LEVEL(OUT_LEVEL), .OUT_HIGH(OUT_HIGH)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .req_i (any_req),
    .irq_o (irq_o)
  );

  // R7: global disable silences the request
  a_r7_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |-> (irq_o != OUT_HIGH));
  // R7: nothing pending and enabled means no request
  a_r7_source_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & src_en) == '0) |-> (irq_o != OUT_HIGH));
endmodule

// File: tb/irq_capture_ctrl_test.sv
`timescale 1ns/100ps

module irq_ref_model #(
  parameter int          N   = 2,
  parameter logic [31:0] LEV = 32'hFFFF_FFFE,
  parameter logic [31:0] HI  = 32'hFFFF_FFFF,
  parameter bit          OL  = 1'b1,
  parameter bit          OH  = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src,
  input  logic         we,
  input  logic [4:0]   wa,
  input  logic [31:0]  wd,
  output logic         irq,
  output logic [31:0]  pend
);
  logic [N-1:0] prv, pd, en;
  logic gen, anyd;
  logic anyv;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) prv[i] = HI[i];
      pd = '0; en = '0; gen = 0; anyd = 0;
    end else begin
      logic [N-1:0] npd;
      anyd = gen && (pd & en) != 0;
      for (int i = 0; i < N; i++) begin
        bit act;
        act = (src[i] == HI[i]);
        if (LEV[i]) npd[i] = act;
        else npd[i] = (act && prv[i] != HI[i]) ||
                      (pd[i] && !(we && wa == 5'h0C && wd[i]));
      end
      pd  = npd;
      prv = src;
      if (we && wa == 5'h04) en  = wd[N-1:0];
      if (we && wa == 5'h00) gen = wd[0];
    end
  end

  assign anyv = gen && ((pd & en) != 0);
  assign irq  = OL ? (anyv == OH) : ((anyv && !anyd) == OH);
  always_comb begin
    pend = '0;
    pend[N-1:0] = pd;
  end
endmodule

module irq_capture_ctrl_test;
  logic clk = 0;
  logic rst_n = 0;
  logic [2:0]  src = 3'b101;
  logic        wr_en = 0;
  logic [4:0]  wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic [4:0]  rd_addr = 5'h08;
  logic [31:0] rd_a, rd_b;
  logic        irq_a, irq_b, m_irq_a, m_irq_b;
  logic [31:0] m_pend_a, m_pend_b;
  int n_cmp = 0, n_bad = 0;
  bit cmp_on = 0, done = 0;

  always #2.5 clk = ~clk;

  // A: src0 rising edge, src1 level high, level output active-high
  irq_capture_ctrl uut (
    .clk(clk), .rst_n(rst_n), .src_i(src[1:0]), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_a), .irq_o(irq_a));

  // B: src0 falling, src1 rising, src2 level low, pulse output active-low
  irq_capture_ctrl #(.NUM_SRC(3), .SRC_LEVEL(32'h0000_0004),
                     .SRC_HIGH(32'h0000_0002), .OUT_LEVEL(1'b0),
                     .OUT_HIGH(1'b0)) uut_b (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_b), .irq_o(irq_b));

  irq_ref_model #(.N(2)) ref_a (
    .clk(clk), .rst_n(rst_n), .src(src[1:0]), .we(wr_en), .wa(wr_addr),
    .wd(wr_data), .irq(m_irq_a), .pend(m_pend_a));

  irq_ref_model #(.N(3), .LEV(32'h4), .HI(32'h2), .OL(1'b0), .OH(1'b0)) ref_b (
    .clk(clk), .rst_n(rst_n), .src(src), .we(wr_en), .wa(wr_addr),
    .wd(wr_data), .irq(m_irq_b), .pend(m_pend_b));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference model
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check("R7 model irq A", {31'd0, irq_a}, {31'd0, m_irq_a});
      check("R9 model irq B", {31'd0, irq_b}, {31'd0, m_irq_b});
      if (rd_addr == 5'h08) begin
        check("R10 model pend A", rd_a, m_pend_a);
        check("R10 model pend B", rd_b, m_pend_b);
      end
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic set_src(input logic [2:0] v);
    @(negedge clk); #1 src = v;
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); #1 wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); #1 wr_en = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] va, output logic [31:0] vb);
    @(negedge clk); #1 rd_addr = a;
    #1 va = rd_a; vb = rd_b;
    rd_addr = 5'h08;
  endtask

  initial begin
    logic [31:0] va, vb;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cmp_on = 1;
    #1;
    // R1 reset state
    check("R1 irq A idle", {31'd0, irq_a}, 0);
    check("R1 irq B idle high", {31'd0, irq_b}, 1);
    rd(5'h08, va, vb); check("R1 pend A", va, 0); check("R1 pend B", vb, 0);
    rd(5'h04, va, vb); check("R1 enable A", va, 0);
    rd(5'h00, va, vb); check("R1 global A", va, 0);

    // R4 input high since reset, enabling does not fire
    wr(5'h00, 1); wr(5'h04, 32'hFFFF_FFFF);
    check("R4 irq A after enable", {31'd0, irq_a}, 0);
    rd(5'h08, va, vb); check("R4 pend A", va, 0);

    // R3 / R9 falling edge on src0
    set_src(3'b100);
    check("R9 pulse B active", {31'd0, irq_b}, 0);
    tick();
    check("R9 pulse B one cycle", {31'd0, irq_b}, 1);
    rd(5'h08, va, vb); check("R3 pend B falling", vb, 1);
    check("R2 rising source ignores fall", va, 0);

    // R2 / R8 rising edge on src0
    set_src(3'b101);
    rd(5'h08, va, vb); check("R2 pend A rising", va, 1);
    check("R8 irq A level", {31'd0, irq_a}, 1);
    tick();
    check("R8 irq A holds", {31'd0, irq_a}, 1);

    // R5 acknowledge
    wr(5'h0C, 32'h2);
    rd(5'h08, va, vb); check("R5 zero ack bit no effect", va, 1);
    wr(5'h0C, 32'h1);
    rd(5'h08, va, vb); check("R5 ack clears", va, 0);
    check("R8 irq A drops", {31'd0, irq_a}, 0);
    wr(5'h04, 0); wr(5'h04, 32'hFFFF_FFFF);
    check("R4 re-enable with input high", {31'd0, irq_a}, 0);

    // R6 level sources
    set_src(3'b111);
    rd(5'h08, va, vb); check("R6 level high pending", va, 2);
    wr(5'h0C, 32'h3);
    rd(5'h08, va, vb); check("R6 ack ignored", va, 2);
    set_src(3'b101);
    rd(5'h08, va, vb); check("R6 level follows low", va, 0);
    check("R8 irq A off", {31'd0, irq_a}, 0);
    set_src(3'b001);
    rd(5'h08, va, vb); check("R6 level-low pending B", vb, 4);
    wr(5'h0C, 32'h4);
    rd(5'h08, va, vb); check("R6 level-low ack ignored", vb, 4);
    set_src(3'b101);
    rd(5'h08, va, vb); check("R6 level-low clears", vb, 0);

    // R11 / R7 disabled capture and gating
    wr(5'h04, 0);
    set_src(3'b100); set_src(3'b101);
    rd(5'h08, va, vb); check("R11 pend while disabled", va, 1);
    check("R7 masked by enable", {31'd0, irq_a}, 0);
    wr(5'h04, 1);
    check("R11 enable raises irq", {31'd0, irq_a}, 1);
    wr(5'h00, 0);
    check("R7 global off", {31'd0, irq_a}, 0);
    wr(5'h00, 1);
    check("R7 global on", {31'd0, irq_a}, 1);

    // R10 register map
    rd(5'h10, va, vb); check("R10 raw A", va, 1); check("R10 raw B", vb, 5);
    rd(5'h04, va, vb); check("R10 enable readback", va, 1);
    rd(5'h00, va, vb); check("R10 global readback", va, 1);
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, va, vb); check("R10 pending read-only", va, 1);
    rd(5'h14, va, vb); check("R10 unused offset", va, 0);
    rd(5'h1C, va, vb); check("R10 unused offset B", vb, 0);

    // R5 edge and ack in the same cycle
    set_src(3'b100);
    @(negedge clk); #1 src = 3'b101; wr_en = 1; wr_addr = 5'h0C; wr_data = 1;
    @(negedge clk); #1 wr_en = 0;
    rd(5'h08, va, vb); check("R5 edge wins over ack", va, 1);
    wr(5'h0C, 1);
    rd(5'h08, va, vb); check("R5 final clear", va, 0);

    tick();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule